// File: doc/BRIEF.md
# Key-protected system control register bank

This block is a bank of 32-bit control and status words for chip-level configuration. It is reached through a plain word-access port with a byte address, a write strobe with data, and a read strobe. The read data is registered. Other logic keeps the clock, reset and pin-routing control words here. The bank only stores those words and reports them back.

Most of the low control words can be written only while the bank is unlocked. The bank is unlocked by writing a magic key into word 0. The reset-control and strap words are changed through paired set and clear addresses. Each strap word has a protect word that freezes its set path. The revision words are read-only. The PLL extension words always report lock. A random-data port produces a new pseudo-random word on every read of it. Reset contents come from fixed values, a revision parameter and strap inputs sampled during reset.

Top module: `sysctl_regs`

## Requirements
- R1: While `rst_n` is low on a rising clock edge, the bank loads these values:
  - the revision words (byte 0x04 and 0x14) load parameter REV;
  - the strap words (0x500 and 0x510) load `strap_a_i` and `strap_b_i`;
  - word 0x00 loads `key_init_i`;
  - 0x40 loads 0xF7CFFFDC, 0x50 loads 0xFFFFFFFC, 0x80 loads 0xEFF43E8B, 0x90 loads 0xFFF0FFF0, 0x100 loads 0x00000040 and 0x200 loads 0x1000405F;
  - every other implemented word loads 0.
- R2: A write to byte 0x00 stores 1 if the data equals parameter KEY (default 0x1688A8A8). Any other data stores 0. The bank is locked while word 0x00 holds 0.
- R3: While the bank is locked, writes to byte offsets 0x04 up to and including 0x100 leave the stored words unchanged. Words at 0x104 and above remain writable while locked.
- R4: A write to a set address (0x40, 0x50) ORs the data into that word. A write to its clear address (0x44, 0x54) clears the bits of the set word where the data is 1. The clear addresses themselves always read 0.
- R5: The strap words at 0x500 and 0x510 use the same scheme, with clear addresses 0x504 and 0x514. While the protect word at strap address + 8 (0x508, 0x518) is nonzero, set writes to that strap word are ignored. Clear writes still take effect.
- R6: Writes to 0x04, 0x14 and 0x540 change nothing readable.
- R7: A read of 0x204, 0x224 or 0x244 returns the stored word with bit 31 forced to 1. Other words read back exactly as stored.
- R8: Each read of 0x540 advances a 32-bit LFSR and returns its new state.
  - The LFSR is a Galois, right-shifting register: next = (s >> 1) XOR (s[0] ? 0x80200003 : 0). It starts at parameter SEED (default 0x1ACEB00C) after reset.
  - Reads of other addresses do not advance it.
  - The value written to the control word at 0x524 has no effect on it.
- R9: An address whose word index (byte address >> 2) is NUM_REGS (default 352) or more reads 0, and a write to it is ignored.
- R10: Read data appears on `rdata_o` in the cycle after `rd_en_i` is sampled and holds until the next read. A read and a write in the same cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_a_i | input | 32 | Reset value of strap word A (0x500) |
| strap_b_i | input | 32 | Reset value of strap word B (0x510) |
| key_init_i | input | 32 | Reset value of the key word (0x00) |
| addr_i | input | ADDR_W (12) | Byte address; bits 1:0 ignored |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Registered read data |

## Verification
The assertions check on every cycle:
- how the key word is stored;
- OR-merging into the first reset word when unlocked, and its freezing when locked;
- the forced lock bit, constant revision reads and zero out-of-range reads;
- that read data holds between reads.

Only the directed scenarios can show the rest:
- the full reset contents;
- clear writes and the strap protect interplay;
- that writes to read-only addresses are discarded;
- the exact LFSR sequence across interleaved reads;
- the pre-write value returned by a simultaneous read and write.

// File: rtl/sysctl_regs_pkg.sv
package sysctl_regs_pkg;

    localparam int WORD_W = 32;

    // Word indices (byte offset >> 2); fixed because behaviour depends on them.
    localparam int IDX_KEY      = 0;
    localparam int IDX_REV_A    = 1;
    localparam int IDX_REV_B    = 5;
    localparam int IDX_RST_SET  = 16;
    localparam int IDX_RST_CLR  = 17;
    localparam int IDX_RST2_SET = 20;
    localparam int IDX_RST2_CLR = 21;
    localparam int IDX_CLKG     = 32;
    localparam int IDX_CLKG2    = 36;
    localparam int IDX_DRAM_HS  = 64;
    localparam int IDX_LOCK_END = 65;   // first index writable while locked
    localparam int IDX_PLL_CFG  = 128;
    localparam int IDX_PLL_X0   = 129;
    localparam int IDX_PLL_X1   = 137;
    localparam int IDX_PLL_X2   = 145;
    localparam int IDX_STRAPA   = 320;
    localparam int IDX_STRAPA_C = 321;
    localparam int IDX_STRAPA_P = 322;
    localparam int IDX_STRAPB   = 324;
    localparam int IDX_STRAPB_C = 325;
    localparam int IDX_STRAPB_P = 326;
    localparam int IDX_RAND     = 336;

    typedef enum logic [2:0] {
        WOP_NONE,
        WOP_PLAIN,
        WOP_OR,
        WOP_ANDN,
        WOP_KEY
    } wop_e;

    function automatic logic [WORD_W-1:0] fixed_reset(input int idx,
                                                      input logic [WORD_W-1:0] rev);
        case (idx)
            IDX_REV_A, IDX_REV_B: return rev;
            IDX_RST_SET:          return 32'hF7CF_FFDC;
            IDX_RST2_SET:         return 32'hFFFF_FFFC;
            IDX_CLKG:             return 32'hEFF4_3E8B;
            IDX_CLKG2:            return 32'hFFF0_FFF0;
            IDX_DRAM_HS:          return 32'h0000_0040;
            IDX_PLL_CFG:          return 32'h1000_405F;
            default:              return '0;
        endcase
    endfunction

endpackage

// File: rtl/sysctl_regs_lfsr.sv
module sysctl_regs_lfsr #(
    parameter int          W    = 32,
    parameter logic [W-1:0] TAPS = 32'h8020_0003,
    parameter logic [W-1:0] SEED = 32'h1ACE_B00C
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_i,
    output logic [W-1:0] next_o
);

    logic [W-1:0] lfsr_d, lfsr_q;

    always_comb begin
        next_o = (lfsr_q >> 1) ^ (lfsr_q[0] ? TAPS : '0);
        lfsr_d = step_i ? next_o : lfsr_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lfsr_q <= SEED;
        else        lfsr_q <= lfsr_d;
    end

endmodule

// File: rtl/sysctl_regs_wpol.sv
module sysctl_regs_wpol
    import sysctl_regs_pkg::*;
#(
    parameter int IDX_W    = 10,
    parameter int SEL_W    = 9,
    parameter int NUM_REGS = 352
) (
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic             locked_i,
    input  logic [WORD_W-1:0] prot_a_i,
    input  logic [WORD_W-1:0] prot_b_i,
    output wop_e             op_o,
    output logic [SEL_W-1:0] tgt_o
);

    logic [SEL_W-1:0] sel;
    assign sel = idx_i[SEL_W-1:0];

    always_comb begin
        op_o  = WOP_NONE;
        tgt_o = sel;
        if (wr_en_i && int'(idx_i) < NUM_REGS) begin
            if (int'(idx_i) == IDX_KEY) begin
                op_o = WOP_KEY;
            end else if (locked_i && int'(idx_i) < IDX_LOCK_END) begin
                op_o = WOP_NONE;
            end else begin
                case (int'(idx_i))
                    IDX_REV_A, IDX_REV_B, IDX_RAND: op_o = WOP_NONE;
                    IDX_RST_SET, IDX_RST2_SET:      op_o = WOP_OR;
                    IDX_STRAPA: op_o = (prot_a_i == '0) ? WOP_OR : WOP_NONE;
                    IDX_STRAPB: op_o = (prot_b_i == '0) ? WOP_OR : WOP_NONE;
                    IDX_RST_CLR, IDX_RST2_CLR, IDX_STRAPA_C, IDX_STRAPB_C: begin
                        op_o  = WOP_ANDN;
                        tgt_o = sel - SEL_W'(1);
                    end
                    default: op_o = WOP_PLAIN;
                endcase
            end
        end
    end

endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
    import sysctl_regs_pkg::*;
#(
    parameter int               ADDR_W   = 12,
    parameter int               NUM_REGS = 352,
    parameter logic [WORD_W-1:0] KEY     = 32'h1688_A8A8,
    parameter logic [WORD_W-1:0] REV     = 32'h0500_0303,
    parameter logic [WORD_W-1:0] SEED    = 32'h1ACE_B00C,
    parameter logic [WORD_W-1:0] TAPS    = 32'h8020_0003
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] strap_a_i,
    input  logic [WORD_W-1:0] strap_b_i,
    input  logic [WORD_W-1:0] key_init_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic              rd_en_i,
    output logic [WORD_W-1:0] rdata_o
);

    localparam int IDX_W = ADDR_W - 2;
    localparam int SEL_W = $clog2(NUM_REGS);

    typedef struct packed {
        logic [NUM_REGS-1:0][WORD_W-1:0] regs;
        logic [WORD_W-1:0]               rdata;
    } state_t;

    state_t state_d, state_q, state_rst;

    logic [IDX_W-1:0] idx;
    logic [SEL_W-1:0] sel;
    logic             unused_low_bits;
    assign idx             = addr_i[ADDR_W-1:2];
    assign sel             = idx[SEL_W-1:0];
    assign unused_low_bits = ^addr_i[1:0];

    // Reset image: strap/key positions from inputs, the rest from constants.
    logic [NUM_REGS-1:0][WORD_W-1:0] rst_words;
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_rst
        if (i == IDX_KEY) begin : g_key
            assign rst_words[i] = key_init_i;
        end else if (i == IDX_STRAPA) begin : g_sa
            assign rst_words[i] = strap_a_i;
        end else if (i == IDX_STRAPB) begin : g_sb
            assign rst_words[i] = strap_b_i;
        end else begin : g_fix
            assign rst_words[i] = fixed_reset(i, REV);
        end
    end

    // Random source
    logic              rand_step;
    logic [WORD_W-1:0] rand_next;
    assign rand_step = rd_en_i && (int'(idx) == IDX_RAND);

    sysctl_regs_lfsr #(
        .W    (WORD_W),
        .TAPS (TAPS),
        .SEED (SEED)
    ) u_lfsr (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (rand_step),
        .next_o (rand_next)
    );

    // Write policy
    wop_e             wop;
    logic [SEL_W-1:0] wtgt;
    logic             locked;
    assign locked = (state_q.regs[IDX_KEY] == '0);

    sysctl_regs_wpol #(
        .IDX_W    (IDX_W),
        .SEL_W    (SEL_W),
        .NUM_REGS (NUM_REGS)
    ) u_wpol (
        .wr_en_i  (wr_en_i),
        .idx_i    (idx),
        .locked_i (locked),
        .prot_a_i (state_q.regs[IDX_STRAPA_P]),
        .prot_b_i (state_q.regs[IDX_STRAPB_P]),
        .op_o     (wop),
        .tgt_o    (wtgt)
    );

    // Read word selection (from pre-write state)
    logic [WORD_W-1:0] rd_word;
    logic              is_pll;
    assign is_pll = (int'(idx) == IDX_PLL_X0) || (int'(idx) == IDX_PLL_X1) ||
                    (int'(idx) == IDX_PLL_X2);

    always_comb begin
        if (int'(idx) >= NUM_REGS) begin
            rd_word = '0;
        end else if (int'(idx) == IDX_RAND) begin
            rd_word = rand_next;
        end else begin
            rd_word = state_q.regs[sel];
            if (is_pll) rd_word[WORD_W-1] = 1'b1;
        end
    end

    always_comb begin
        state_rst.regs  = rst_words;
        state_rst.rdata = '0;
    end

    always_comb begin
        state_d = state_q;
        case (wop)
            WOP_KEY:   state_d.regs[IDX_KEY] = (wdata_i == KEY) ? WORD_W'(1) : '0;
            WOP_PLAIN: state_d.regs[wtgt]    = wdata_i;
            WOP_OR:    state_d.regs[wtgt]    = state_q.regs[wtgt] | wdata_i;
            WOP_ANDN:  state_d.regs[wtgt]    = state_q.regs[wtgt] & ~wdata_i;
            default:   ;
        endcase
        if (rd_en_i) state_d.rdata = rd_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= state_rst;
        else        state_q <= state_d;
    end

    assign rdata_o = state_q.rdata;

endmodule

// File: rtl/sysctl_regs_chk.sv
module sysctl_regs_chk #(
    parameter int          ADDR_W   = 12,
    parameter int          NUM_REGS = 352,
    parameter logic [31:0] KEY      = 32'h1688_A8A8,
    parameter logic [31:0] REV      = 32'h0500_0303
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr_i,
    input logic              wr_en_i,
    input logic [31:0]       wdata_i,
    input logic              rd_en_i,
    input logic [31:0]       rdata_o,
    input logic [31:0]       key_word,
    input logic [31:0]       set_word
);

    logic [ADDR_W-3:0] idx;
    logic              unused_chk_bits;
    assign idx             = addr_i[ADDR_W-1:2];
    assign unused_chk_bits = ^addr_i[1:0];

    // R2
    a_r2_key_store: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i && int'(idx) == 0 |=> key_word == {31'b0, $past(wdata_i) == KEY});

    // R4
    a_r4_set_or: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i && int'(idx) == 16 && key_word != 0
        |=> set_word == ($past(set_word) | $past(wdata_i)));

    // R3
    a_r3_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i && (int'(idx) == 16 || int'(idx) == 17) && key_word == 0
        |=> $stable(set_word));

    // R7
    a_r7_pll_lock: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_i && (int'(idx) == 129 || int'(idx) == 137 || int'(idx) == 145)
        |=> rdata_o[31]);

    // R6
    a_r6_rev_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_i && (int'(idx) == 1 || int'(idx) == 5) |=> rdata_o == REV);

    // R9
    a_r9_oob_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_i && int'(idx) >= NUM_REGS |=> rdata_o == 32'h0);

    // R10
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> $stable(rdata_o));

endmodule

bind sysctl_regs sysctl_regs_chk #(
    .ADDR_W   (ADDR_W),
    .NUM_REGS (NUM_REGS),
    .KEY      (KEY),
    .REV      (REV)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_i   (addr_i),
    .wr_en_i  (wr_en_i),
    .wdata_i  (wdata_i),
    .rd_en_i  (rd_en_i),
    .rdata_o  (rdata_o),
    .key_word (state_q.regs[0]),
    .set_word (state_q.regs[16])
);

// File: tb/tb_sysctl_regs.sv
module tb_sysctl_regs;

    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] KEY        = 32'h1688_A8A8;
    localparam logic [31:0] REV        = 32'h0500_0303;
    localparam logic [31:0] SEED       = 32'h1ACE_B00C;
    localparam logic [31:0] STRAP_A    = 32'h00A5_5A01;
    localparam logic [31:0] STRAP_B    = 32'h1234_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] strap_a, strap_b, key_init;
    logic [11:0] addr;
    logic        wr_en, rd_en;
    logic [31:0] wdata;
    logic [31:0] rdata;

    int          n_tests = 0;
    int          n_fail  = 0;
    bit          done    = 0;
    logic [31:0] rng_m   = SEED;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sysctl_regs dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap_a_i  (strap_a),
        .strap_b_i  (strap_b),
        .key_init_i (key_init),
        .addr_i     (addr),
        .wr_en_i    (wr_en),
        .wdata_i    (wdata),
        .rd_en_i    (rd_en),
        .rdata_o    (rdata)
    );

    function automatic logic [31:0] rng_step(input logic [31:0] s);
        return (s >> 1) ^ (s[0] ? 32'h8020_0003 : 32'h0);
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic rd_check(input string tag, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(tag, v, exp);
    endtask

    task automatic t_reset();
        rd_check("R1 rev a",   12'h004, REV);
        rd_check("R1 rev b",   12'h014, REV);
        rd_check("R1 strap a", 12'h500, STRAP_A);
        rd_check("R1 strap b", 12'h510, STRAP_B);
        rd_check("R1 key",     12'h000, 32'h0);
        rd_check("R1 rst",     12'h040, 32'hF7CF_FFDC);
        rd_check("R1 rst2",    12'h050, 32'hFFFF_FFFC);
        rd_check("R1 clk",     12'h080, 32'hEFF4_3E8B);
        rd_check("R1 clk2",    12'h090, 32'hFFF0_FFF0);
        rd_check("R1 dram",    12'h100, 32'h0000_0040);
        rd_check("R1 pll",     12'h200, 32'h1000_405F);
        rd_check("R1 plain",   12'h008, 32'h0);
    endtask

    task automatic t_locked();
        wr(12'h008, 32'hDEAD_BEEF);
        rd_check("R3 locked plain", 12'h008, 32'h0);
        wr(12'h040, 32'h0000_0023);
        rd_check("R3 locked set", 12'h040, 32'hF7CF_FFDC);
        wr(12'h100, 32'h0);
        rd_check("R3 locked 0x100", 12'h100, 32'h0000_0040);
        wr(12'h104, 32'h0000_0055);
        rd_check("R3 open 0x104", 12'h104, 32'h0000_0055);
        wr(12'h300, 32'h0000_00AA);
        rd_check("R3 open 0x300", 12'h300, 32'h0000_00AA);
    endtask

    task automatic t_key();
        wr(12'h000, KEY);
        rd_check("R2 key ok", 12'h000, 32'h1);
        wr(12'h008, 32'h0000_CAFE);
        rd_check("R2 unlocked write", 12'h008, 32'h0000_CAFE);
        wr(12'h000, KEY + 32'h1);
        rd_check("R2 key bad", 12'h000, 32'h0);
        wr(12'h008, 32'h1);
        rd_check("R2 relocked", 12'h008, 32'h0000_CAFE);
        wr(12'h000, KEY);
        rd_check("R2 key again", 12'h000, 32'h1);
    endtask

    task automatic t_setclr();
        wr(12'h040, 32'h0000_0023);
        rd_check("R4 set or", 12'h040, 32'hF7CF_FFFF);
        wr(12'h044, 32'hF000_0001);
        rd_check("R4 clear", 12'h040, 32'h07CF_FFFE);
        rd_check("R4 clear addr reads 0", 12'h044, 32'h0);
        wr(12'h054, 32'hFFFF_0000);
        rd_check("R4 clear pair2", 12'h050, 32'h0000_FFFC);
    endtask

    task automatic t_strap();
        wr(12'h500, 32'h0F00_0000);
        rd_check("R5 strap set", 12'h500, 32'h0FA5_5A01);
        wr(12'h508, 32'h1);
        wr(12'h500, 32'h3000_0000);
        rd_check("R5 protected set", 12'h500, 32'h0FA5_5A01);
        wr(12'h504, 32'h0000_0001);
        rd_check("R5 clear under protect", 12'h500, 32'h0FA5_5A00);
        wr(12'h510, 32'h0000_0001);
        rd_check("R5 strap b set", 12'h510, 32'h1234_0001);
        wr(12'h518, 32'h8000_0000);
        wr(12'h510, 32'h0000_0100);
        rd_check("R5 strap b protected", 12'h510, 32'h1234_0001);
    endtask

    task automatic t_readonly();
        wr(12'h004, 32'h0);
        rd_check("R6 rev a ro", 12'h004, REV);
        wr(12'h014, 32'hFFFF_FFFF);
        rd_check("R6 rev b ro", 12'h014, REV);
        wr(12'h540, 32'h1234_5678);
        rng_m = rng_step(rng_m);
        rd_check("R6 rand ro", 12'h540, rng_m);
    endtask

    task automatic t_pll();
        wr(12'h204, 32'h0000_0012);
        rd_check("R7 pll x0", 12'h204, 32'h8000_0012);
        wr(12'h224, 32'h8000_0000);
        rd_check("R7 pll x1", 12'h224, 32'h8000_0000);
        rd_check("R7 pll x2", 12'h244, 32'h8000_0000);
        wr(12'h208, 32'h0000_0012);
        rd_check("R7 non-pll exact", 12'h208, 32'h0000_0012);
    endtask

    task automatic t_rand();
        wr(12'h524, 32'h0);
        rng_m = rng_step(rng_m);
        rd_check("R8 rand 1", 12'h540, rng_m);
        rd_check("R8 other read", 12'h008, 32'h0000_CAFE);
        rng_m = rng_step(rng_m);
        rd_check("R8 rand 2", 12'h540, rng_m);
        wr(12'h524, 32'hFFFF_FFFF);
        for (int k = 0; k < 5; k++) begin
            rng_m = rng_step(rng_m);
            rd_check("R8 rand seq", 12'h540, rng_m);
        end
    endtask

    task automatic t_oob();
        wr(12'h600, 32'h0000_FFFF);
        rd_check("R9 oob read", 12'h600, 32'h0);
        rd_check("R9 oob top", 12'hFFC, 32'h0);
        wr(12'h57C, 32'h0000_0BEE);
        rd_check("R9 last valid", 12'h57C, 32'h0000_0BEE);
    endtask

    task automatic t_timing();
        logic [31:0] v;
        addr = 12'h00C; wdata = 32'h0000_0077; wr_en = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check("R10 read before write", rdata, 32'h0);
        v = rdata;
        addr = 12'h040;
        repeat (3) @(negedge clk);
        check("R10 hold", rdata, v);
        rd_check("R10 after write", 12'h00C, 32'h0000_0077);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got %h expected %h", 32'h0, 32'h1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        strap_a = STRAP_A; strap_b = STRAP_B; key_init = 32'h0;
        addr = '0; wdata = '0; wr_en = 1'b0; rd_en = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 rdata after reset", rdata, 32'h0);
        t_reset();
        t_locked();
        t_key();
        t_setclr();
        t_strap();
        t_readonly();
        t_pll();
        t_rand();
        t_oob();
        t_timing();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule